// File: doc/BRIEF.md
# PWM Watchdog Force-On Timer

This block guards an LED pulse-width controller against firmware that stops servicing it. Software stores an 8-bit reload value. The block copies that value into a down-counter. The counter then loses one unit on every pulse of a slow 5 Hz enable strobe, so each reload unit is worth 200 ms. A value of 1 gives 200 ms, 0x14 gives 4 s and 0xFF gives 51 s. Software keeps the count away from zero by pulsing a kick input or by writing a new reload value.

If the count does reach zero, the block does not reset the system. It raises a one-clock interrupt. In the same cycle it sends a strobe to the PWM datapath that carries the full-on code for the 2-bit control field. No other setting of the datapath is touched. A sticky status flag records the expiry until software clears it.

If the 5 Hz strobe stops, the count freezes and keeps its value. When the strobe returns, counting resumes from that value. A stored reload value of zero turns the timer off.

Top module: `pwm_wdt_force`

## Requirements
- R1: After a synchronous active-high reset, count, irqPulse, forceStb, forceCode, status and the stored reload value are all zero.
- R2: A cycle with reloadWr high stores reloadData. It also loads count with reloadData, and the new value is visible after that clock edge.
- R3: In a cycle with tick high, count nonzero and no load, count drops by exactly one. When count is zero, tick leaves it unchanged.
- R4: In cycles with tick low, count holds its value. When ticks resume, counting continues from the held value.
- R5: The tick that takes count from 1 to 0 causes three things after that edge, for exactly one cycle: irqPulse is 1, forceStb is 1 and forceCode is 2'b11 (full on). In every other cycle forceCode is 2'b00.
- R6: Once count is 0, it stays 0 and raises no further interrupt or force strobe until it is loaded again.
- R7: Writing a reload value of zero clears count and disables the timer. Later ticks and kicks then cause no interrupt and leave count at 0.
- R8: A kick loads count from the stored reload value. A load, whether from a kick or a write, takes priority over a tick in the same cycle. A write and a kick in the same cycle load the newly written value.
- R9: status becomes 1 on a terminal count and stays 1 until a cycle with statusClr high clears it. If a terminal count and statusClr fall in the same cycle, status ends up 1.
- R10: With a reload value N loaded and no further loads, irqPulse follows the Nth tick after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse at 5 Hz |
| reloadWr | input | 1 | Write strobe for the reload value |
| reloadData | input | 8 | Reload value, in units of 200 ms |
| kick | input | 1 | Reload the count from the stored value |
| statusClr | input | 1 | Write-one-to-clear for the status flag |
| irqPulse | output | 1 | One-clock interrupt on terminal count |
| forceStb | output | 1 | Strobe telling the PWM to take forceCode |
| forceCode | output | 2 | Control code to force, 2'b11 = full on |
| count | output | 8 | Present counter value |
| status | output | 1 | Sticky expiry flag |

## Verification
Every result of this block is registered once. A load, a decrement, the interrupt, the force strobe and the status change all show at the ports after the same rising edge that samples the stimulus. No result of this block arrives later than that edge. The driver applies inputs on the falling edge and computes the expected port values from the requirements after the next rising edge. It then queues them, and the monitor pops and compares them on the following falling edge. Each stimulus cycle therefore meets its result exactly one edge later, with no search window.

// File: rtl/pwm_wdt_pkg.sv
package pwm_wdt_pkg;
  // Strobes from control to datapath, one clock wide each.
  typedef struct packed {
    logic load;   // copy the selected reload value into the counter
    logic dec;    // subtract one from the counter
    logic fire;   // this decrement is the terminal count
  } wdtStrobes_t;
endpackage

// File: rtl/pwm_wdt_ctrl.sv
module pwm_wdt_ctrl
  import pwm_wdt_pkg::*;
(
  input  logic        tick,
  input  logic        kick,
  input  logic        reloadWr,
  input  logic        cntZero,
  input  logic        cntOne,
  output wdtStrobes_t strb
);
  always_comb begin
    strb.load = reloadWr | kick;
    // A load wins over a decrement; a zero count does not move.
    strb.dec  = tick & ~cntZero & ~strb.load;
    strb.fire = strb.dec & cntOne;
  end
endmodule

// File: rtl/pwm_wdt_dp.sv
module pwm_wdt_dp
  import pwm_wdt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 2,
  parameter logic [CODE_W-1:0] FULL_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  wdtStrobes_t       strb,
  input  logic              reloadWr,
  input  logic [CNT_W-1:0]  reloadData,
  input  logic              statusClr,
  output logic [CNT_W-1:0]  count,
  output logic              cntZero,
  output logic              cntOne,
  output logic              irqPulse,
  output logic              forceStb,
  output logic [CODE_W-1:0] forceCode,
  output logic              status
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] loadVal;

  // A write in the same cycle as a kick supplies the fresh value.
  assign loadVal = reloadWr ? reloadData : reloadReg;
  assign cntZero = (count == '0);
  assign cntOne  = (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadReg <= '0;
    end else if (reloadWr) begin
      reloadReg <= reloadData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strb.load) begin
      count <= loadVal;
    end else if (strb.dec) begin
      count <= count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqPulse  <= 1'b0;
      forceStb  <= 1'b0;
      forceCode <= '0;
    end else begin
      irqPulse  <= strb.fire;
      forceStb  <= strb.fire;
      forceCode <= strb.fire ? FULL_CODE : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
    end else if (strb.fire) begin
      status <= 1'b1;
    end else if (statusClr) begin
      status <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_wdt_force.sv
module pwm_wdt_force
  import pwm_wdt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 2,
  parameter logic [CODE_W-1:0] FULL_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              reloadWr,
  input  logic [CNT_W-1:0]  reloadData,
  input  logic              kick,
  input  logic              statusClr,
  output logic              irqPulse,
  output logic              forceStb,
  output logic [CODE_W-1:0] forceCode,
  output logic [CNT_W-1:0]  count,
  output logic              status
);
  wdtStrobes_t strb;
  logic        cntZero;
  logic        cntOne;

  pwm_wdt_ctrl u_ctrl (
    .tick     (tick),
    .kick     (kick),
    .reloadWr (reloadWr),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .strb     (strb)
  );

  pwm_wdt_dp #(
    .CNT_W     (CNT_W),
    .CODE_W    (CODE_W),
    .FULL_CODE (FULL_CODE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .reloadWr   (reloadWr),
    .reloadData (reloadData),
    .statusClr  (statusClr),
    .count      (count),
    .cntZero    (cntZero),
    .cntOne     (cntOne),
    .irqPulse   (irqPulse),
    .forceStb   (forceStb),
    .forceCode  (forceCode),
    .status     (status)
  );
endmodule

// File: rtl/pwm_wdt_force_chk.sv
module pwm_wdt_force_chk #(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 2,
  parameter logic [CODE_W-1:0] FULL_CODE = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              reloadWr,
  input logic [CNT_W-1:0]  reloadData,
  input logic              kick,
  input logic              irqPulse,
  input logic              forceStb,
  input logic [CODE_W-1:0] forceCode,
  input logic [CNT_W-1:0]  count,
  input logic              status
);
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    reloadWr |=> count == $past(reloadData));

  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (tick && !kick && !reloadWr && count != '0) |=> count == CNT_W'($past(count) - 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !kick && !reloadWr) |=> $stable(count));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);

  a_r5_force_full: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> (forceStb && forceCode == FULL_CODE && count == '0));

  a_r6_no_refire: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !kick && !reloadWr) |=> !irqPulse);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> status);
endmodule

bind pwm_wdt_force pwm_wdt_force_chk #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .FULL_CODE(FULL_CODE)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .reloadWr(reloadWr),
  .reloadData(reloadData), .kick(kick), .irqPulse(irqPulse),
  .forceStb(forceStb), .forceCode(forceCode), .count(count),
  .status(status)
);

// File: tb/tb_pwm_wdt_force.sv
module tb_pwm_wdt_force;
  logic       clk = 1'b0;
  logic       rst, tick, reloadWr, kick, statusClr;
  logic [7:0] reloadData;
  logic       irqPulse, forceStb, status;
  logic [1:0] forceCode;
  logic [7:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] cnt;
    logic       irq;
    logic       frc;
    logic [1:0] code;
    logic       st;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state, kept from the requirements.
  logic [7:0] mCnt = 0, mRel = 0;
  logic       mSt = 0;

  always #10 clk = ~clk;

  pwm_wdt_force dut (
    .clk(clk), .rst(rst), .tick(tick), .reloadWr(reloadWr),
    .reloadData(reloadData), .kick(kick), .statusClr(statusClr),
    .irqPulse(irqPulse), .forceStb(forceStb), .forceCode(forceCode),
    .count(count), .status(status)
  );

  // Driver: one stimulus cycle, expected result pushed after the edge.
  task automatic cyc(input logic r, input logic t, input logic w,
                     input logic [7:0] d, input logic k, input logic c,
                     input string tag);
    expItem_t e;
    logic fire;
    logic [7:0] lv;
    @(negedge clk);
    rst = r; tick = t; reloadWr = w; reloadData = d; kick = k; statusClr = c;
    fire = 1'b0;
    if (r) begin
      mCnt = 0; mRel = 0; mSt = 0;
    end else begin
      lv = w ? d : mRel;
      if (w) mRel = d;
      if (w || k) mCnt = lv;
      else if (t && mCnt != 0) begin
        fire = (mCnt == 8'd1);
        mCnt = mCnt - 8'd1;
      end
      if (fire) mSt = 1'b1;
      else if (c) mSt = 1'b0;
    end
    e.cnt = mCnt; e.irq = fire; e.frc = fire;
    e.code = fire ? 2'b11 : 2'b00; e.st = mSt; e.tag = tag;
    @(posedge clk);
    #1 expQ.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 0, 0, tag);
  endtask

  // Monitor: compare one queued item per falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (count !== e.cnt || irqPulse !== e.irq || forceStb !== e.frc ||
          forceCode !== e.code || status !== e.st) begin
        fails++;
        $display("FAIL %s: got cnt=%0d irq=%b frc=%b code=%b st=%b, expected cnt=%0d irq=%b frc=%b code=%b st=%b",
                 e.tag, count, irqPulse, forceStb, forceCode, status,
                 e.cnt, e.irq, e.frc, e.code, e.st);
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; tick = 0; reloadWr = 0; reloadData = 0; kick = 0; statusClr = 0;
    cyc(1, 0, 0, 8'h00, 0, 0, "R1 reset");
    cyc(1, 1, 1, 8'h33, 1, 0, "R1 reset");
    idle(1, "R1 after reset");
    cyc(0, 1, 0, 8'h00, 0, 0, "R7 tick while disabled");
    // Load 3, count down with gaps between ticks.
    cyc(0, 0, 1, 8'h03, 0, 0, "R2 write load");
    cyc(0, 1, 0, 8'h00, 0, 0, "R3 decrement");
    idle(3, "R4 hold without tick");
    cyc(0, 1, 0, 8'h00, 0, 0, "R4 resume");
    idle(1, "R4 hold");
    cyc(0, 1, 0, 8'h00, 0, 0, "R5 R10 terminal count");
    idle(2, "R5 pulse ends");
    cyc(0, 1, 0, 8'h00, 0, 0, "R6 tick at zero");
    cyc(0, 1, 0, 8'h00, 0, 0, "R6 tick at zero");
    cyc(0, 0, 0, 8'h00, 0, 1, "R9 status clear");
    // Kick priority.
    cyc(0, 0, 1, 8'h05, 0, 0, "R2 write 5");
    cyc(0, 1, 0, 8'h00, 0, 0, "R3 decrement");
    cyc(0, 1, 0, 8'h00, 0, 0, "R3 decrement");
    cyc(0, 1, 0, 8'h00, 1, 0, "R8 kick beats tick");
    cyc(0, 0, 0, 8'h00, 1, 0, "R8 kick");
    cyc(0, 1, 1, 8'h02, 1, 0, "R8 write plus kick");
    cyc(0, 1, 0, 8'h00, 0, 0, "R3 decrement");
    // Terminal count with clear in the same cycle.
    cyc(0, 1, 0, 8'h00, 0, 1, "R9 set beats clear");
    idle(1, "R9 sticky");
    cyc(0, 0, 0, 8'h00, 1, 1, "R8 R9 kick reload and clear");
    // Full-count run: N ticks to expiry.
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, 8'h00, 0, 0, "R10 countdown");
    idle(1, "R10 after expiry");
    cyc(0, 0, 1, 8'h14, 0, 0, "R2 write 0x14");
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 0, 8'h00, 0, 0, "R10 twenty ticks");
      idle(1, "R10 gap");
    end
    // Disable.
    cyc(0, 0, 1, 8'hFF, 0, 0, "R2 write 0xFF");
    cyc(0, 1, 0, 8'h00, 0, 0, "R3 decrement");
    cyc(0, 0, 1, 8'h00, 0, 0, "R7 zero write clears");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 8'h00, i[0], 0, "R7 disabled");
    cyc(0, 0, 1, 8'h01, 0, 0, "R2 write 1");
    cyc(0, 1, 0, 8'h00, 0, 0, "R10 single tick expiry");
    idle(2, "R6 stays zero");
    cyc(1, 0, 0, 8'h00, 0, 0, "R1 reset clears status");
    idle(1, "R1 reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule